// File: doc/BRIEF.md
# Boot-Block Top-Swap Address Inverter

This block sits on the host address path toward the boot ROM at the top of the 4 GB space. When the top-swap state is active and an access falls inside the ROM window, it flips one address bit. The effect is that fetches to the primary boot block land in the backup boot block of the same size directly below it. For example, the reset-vector fetch at 0xFFFFFFF0 becomes a fetch at 0xFFFEFFF0 when the boot block is 64 KB.

A 3-bit size code chooses the flipped bit. Codes 0 to 4 select address bits 16 to 20, and codes 5 to 7 fall back to bit 16. The address path is purely combinational, so it adds no cycles to a fetch.

Two state bits are written through a simple write port:
- The swap bit lives in the RTC well. It keeps its value across platform resets and clears only on the RTC-well reset.
- The lock bit is write-once and clears on platform reset. While it is set, the swap bit cannot be changed.

Top module: `boot_swap_remap`

## Requirements
- R1: When `romHit` is 0, `addrOut` equals `addrIn` whatever the swap state.
- R2: When the swap state is clear, `addrOut` equals `addrIn` even when `romHit` is 1.
- R3: When the swap state is set and `romHit` is 1, `addrOut` equals `addrIn` with exactly one bit inverted. Size codes 0, 1, 2, 3 and 4 select address bits 16, 17, 18, 19 and 20 respectively.
- R4: Size codes 5, 6 and 7 invert address bit 16.
- R5: With the swap state set, size code 0 and `romHit` 1, address 0xFFFFFFF0 maps to 0xFFFEFFF0.
- R6: The swap state keeps its value through a platform reset (`platRstN` low) and clears on an RTC-well reset (`rtcRstN` low).
- R7: While the lock is set, a write never changes the swap state.
- R8: The lock is set by a write with `wrLock` 1. A later write with `wrLock` 0 does not clear it. A platform reset or an RTC-well reset clears it.
- R9: With the lock clear, a write (`wrEn` 1 at a rising clock edge) loads `wrSwap` into the swap state, and the new mapping is visible after that edge.
- R10: After an RTC-well reset, the swap state and the lock are both clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the state bits |
| platRstN | input | 1 | Platform reset, active low, asynchronous; clears the lock |
| rtcRstN | input | 1 | RTC-well reset, active low, asynchronous; clears swap and lock |
| addrIn | input | 32 | Host address toward the ROM |
| romHit | input | 1 | Address falls inside the boot ROM window |
| blockSizeSel | input | 3 | Boot-block size code selecting the inverted bit |
| wrEn | input | 1 | Write strobe for the state bits |
| wrSwap | input | 1 | Write data for the swap bit |
| wrLock | input | 1 | Write data for the lock bit (set-only) |
| addrOut | output | 32 | Remapped address |

## Verification
Several properties are checked on every cycle by assertions:
- the pass-through outside the ROM window (R1);
- the pass-through when the swap state is clear (R2);
- the fact that at most one address bit ever differs (R3);
- the frozen swap state under lock (R7);
- the stickiness of the lock between resets (R8).

Other behaviours appear only in the bench's scenarios:
- which bit each size code selects, including the reserved codes;
- the exact reset-vector redirection;
- survival of the swap state through a platform reset while the lock clears;
- the swap state clearing on the RTC-well reset.

// File: rtl/boot_swap_pkg.sv
package boot_swap_pkg;
  parameter int ADDR_W    = 32;
  parameter int BASE_BIT  = 16;
  parameter int NUM_SIZES = 5;
  parameter int SEL_W     = 3;

  typedef struct packed {
    logic invertEn;
  } swapStrobes_t;
endpackage

// File: rtl/boot_swap_ctrl.sv
module boot_swap_ctrl
  import boot_swap_pkg::*;
(
  input  logic         clk,
  input  logic         platRstN,
  input  logic         rtcRstN,
  input  logic         romHit,
  input  logic         wrEn,
  input  logic         wrSwap,
  input  logic         wrLock,
  output swapStrobes_t strobes,
  output logic         swapQ,
  output logic         lockQ
);
  logic lockRstN;
  assign lockRstN = platRstN & rtcRstN;

  // Swap bit: RTC-well domain, survives platform reset.
  always_ff @(posedge clk or negedge rtcRstN) begin
    if (!rtcRstN) swapQ <= 1'b0;
    else if (wrEn && !lockQ) swapQ <= wrSwap;
  end

  // Lock bit: set-only, cleared by platform (or RTC) reset.
  always_ff @(posedge clk or negedge lockRstN) begin
    if (!lockRstN) lockQ <= 1'b0;
    else if (wrEn && wrLock) lockQ <= 1'b1;
  end

  always_comb begin
    strobes.invertEn = swapQ & romHit;
  end
endmodule

// File: rtl/boot_swap_datapath.sv
module boot_swap_datapath
  import boot_swap_pkg::*;
(
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [SEL_W-1:0]  blockSizeSel,
  input  swapStrobes_t      strobes,
  output logic [ADDR_W-1:0] addrOut
);
  logic [ADDR_W-1:0] maskOpts [NUM_SIZES];
  logic [ADDR_W-1:0] flipMask;

  genvar g;
  generate
    for (g = 0; g < NUM_SIZES; g++) begin : gMask
      assign maskOpts[g] = ADDR_W'(1) << (BASE_BIT + g);
    end
  endgenerate

  always_comb begin
    flipMask = maskOpts[0];
    for (int i = 1; i < NUM_SIZES; i++) begin
      if (int'(blockSizeSel) == i) flipMask = maskOpts[i];
    end
  end

  assign addrOut = strobes.invertEn ? (addrIn ^ flipMask) : addrIn;
endmodule

// File: rtl/boot_swap_remap.sv
module boot_swap_remap
  import boot_swap_pkg::*;
(
  input  logic              clk,
  input  logic              platRstN,
  input  logic              rtcRstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              romHit,
  input  logic [SEL_W-1:0]  blockSizeSel,
  input  logic              wrEn,
  input  logic              wrSwap,
  input  logic              wrLock,
  output logic [ADDR_W-1:0] addrOut
);
  swapStrobes_t strobes;
  logic swapState;
  logic lockState;

  boot_swap_ctrl uCtrl (
    .clk(clk), .platRstN(platRstN), .rtcRstN(rtcRstN), .romHit(romHit),
    .wrEn(wrEn), .wrSwap(wrSwap), .wrLock(wrLock),
    .strobes(strobes), .swapQ(swapState), .lockQ(lockState)
  );

  boot_swap_datapath uData (
    .addrIn(addrIn), .blockSizeSel(blockSizeSel),
    .strobes(strobes), .addrOut(addrOut)
  );
endmodule

// File: rtl/boot_swap_checker.sv
module boot_swap_checker
  import boot_swap_pkg::*;
(
  input logic              clk,
  input logic              platRstN,
  input logic              rtcRstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              romHit,
  input logic [ADDR_W-1:0] addrOut,
  input logic              swapState,
  input logic              lockState
);
  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rtcRstN || !platRstN)
    !romHit |-> addrOut == addrIn);

  assert_noswap_R2: assert property (@(posedge clk) disable iff (!rtcRstN || !platRstN)
    !swapState |-> addrOut == addrIn);

  assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rtcRstN || !platRstN)
    $countones(addrOut ^ addrIn) <= 1);

  assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (!rtcRstN || !platRstN)
    lockState |=> $stable(swapState));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rtcRstN || !platRstN)
    lockState |=> lockState);
endmodule

bind boot_swap_remap boot_swap_checker uChk (
  .clk(clk), .platRstN(platRstN), .rtcRstN(rtcRstN), .addrIn(addrIn),
  .romHit(romHit), .addrOut(addrOut), .swapState(swapState), .lockState(lockState)
);

// File: tb/boot_swap_remap_test.sv
module boot_swap_remap_test;
  logic        clk = 1'b0;
  logic        platRstN = 1'b0;
  logic        rtcRstN = 1'b0;
  logic [31:0] addrIn = '0;
  logic        romHit = 1'b0;
  logic [2:0]  blockSizeSel = '0;
  logic        wrEn = 1'b0;
  logic        wrSwap = 1'b0;
  logic        wrLock = 1'b0;
  logic [31:0] addrOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  boot_swap_remap uut (
    .clk(clk), .platRstN(platRstN), .rtcRstN(rtcRstN), .addrIn(addrIn),
    .romHit(romHit), .blockSizeSel(blockSizeSel), .wrEn(wrEn),
    .wrSwap(wrSwap), .wrLock(wrLock), .addrOut(addrOut)
  );

  // {romHit, sizeSel, addrIn, expected} with swap set
  localparam logic [67:0] VEC [10] = '{
    {1'b1, 3'd0, 32'hFFFFFFF0, 32'hFFFEFFF0},
    {1'b1, 3'd1, 32'hFFFFFFF0, 32'hFFFDFFF0},
    {1'b1, 3'd2, 32'hFFFFFFF0, 32'hFFFBFFF0},
    {1'b1, 3'd3, 32'hFFFFFFF0, 32'hFFF7FFF0},
    {1'b1, 3'd4, 32'hFFFFFFF0, 32'hFFEFFFF0},
    {1'b1, 3'd5, 32'hFFFFFFF0, 32'hFFFEFFF0},
    {1'b1, 3'd7, 32'hFFFF0000, 32'hFFFE0000},
    {1'b0, 3'd0, 32'hFFFFFFF0, 32'hFFFFFFF0},
    {1'b1, 3'd4, 32'hFFE01234, 32'hFFF01234},
    {1'b1, 3'd6, 32'hFFFE0000, 32'hFFFF0000}
  };

  task automatic probe(input logic hit, input logic [2:0] sel, input logic [31:0] a,
                       input logic [31:0] exp, input string req);
    @(negedge clk);
    romHit = hit; blockSizeSel = sel; addrIn = a;
    #1;
    checks++;
    if (addrOut !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, addrOut, exp);
    end
  endtask

  task automatic doWrite(input logic s, input logic l);
    @(negedge clk);
    wrEn = 1'b1; wrSwap = s; wrLock = l;
    @(negedge clk);
    wrEn = 1'b0; wrSwap = 1'b0; wrLock = 1'b0;
  endtask

  task automatic pulsePlat();
    @(negedge clk); platRstN = 1'b0;
    @(negedge clk); platRstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rtcRstN = 1'b1; platRstN = 1'b1;
    // R10 / R2: reset state means no swap
    probe(1'b1, 3'd0, 32'hFFFFFFF0, 32'hFFFFFFF0, "R10 reset state");
    probe(1'b1, 3'd2, 32'hFFFC0000, 32'hFFFC0000, "R2 swap clear");
    // R9: write swap
    doWrite(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) begin
      probe(VEC[i][67], VEC[i][66:64], VEC[i][63:32], VEC[i][31:0],
            $sformatf("table %0d (R1 R3 R4 R5)", i));
    end
    // R6: survives platform reset
    pulsePlat();
    probe(1'b1, 3'd0, 32'hFFFFFFF0, 32'hFFFEFFF0, "R6 swap kept over platform reset");
    // R7: lock blocks swap change
    doWrite(1'b1, 1'b1);
    doWrite(1'b0, 1'b0);
    probe(1'b1, 3'd0, 32'hFFFFFFF0, 32'hFFFEFFF0, "R7 locked swap unchanged");
    // R8: lock not cleared by write of 0
    doWrite(1'b0, 1'b0);
    probe(1'b1, 3'd1, 32'hFFFFFFF0, 32'hFFFDFFF0, "R8 lock sticky");
    // R8: platform reset clears lock, swap stays (R6)
    pulsePlat();
    probe(1'b1, 3'd0, 32'hFFFFFFF0, 32'hFFFEFFF0, "R6 swap after lock clear");
    doWrite(1'b0, 1'b0);
    probe(1'b1, 3'd0, 32'hFFFFFFF0, 32'hFFFFFFF0, "R8 lock cleared by platform reset, R9 write");
    // R6 / R10: RTC reset clears swap and lock
    doWrite(1'b1, 1'b1);
    @(negedge clk); rtcRstN = 1'b0;
    @(negedge clk); rtcRstN = 1'b1;
    probe(1'b1, 3'd0, 32'hFFFFFFF0, 32'hFFFFFFF0, "R6 RTC reset clears swap");
    doWrite(1'b1, 1'b0);
    probe(1'b1, 3'd3, 32'hFFFFFFF0, 32'hFFF7FFF0, "R10 lock clear after RTC reset");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule